// File: doc/BRIEF.md
# Variable-Latency Instruction Step Sequencer

This block is the control sequencer of a small, non-pipelined, low-power coprocessor. It moves each instruction through a fetch phase and then an execute phase, and the two never overlap. The fetch phase is short when the instruction just retired was an arithmetic/logic or branch operation, and long otherwise. The execute phase has a fixed length for each instruction class. A wait instruction adds its own cycle operand. Measurement and bus-transfer classes run until an external completion input arrives.

The sequencer owns the program counter and raises a fetch strobe for as long as instruction memory is being read. Decode logic outside the block presents the class code and the wait operand during the last fetch cycle. The sequencer latches the class and holds it through execute, then gives a one-cycle completion pulse. A memory-arbiter stall freezes whichever phase is running. A halt instruction parks the block until a start pulse supplies a new entry address. When the wakeup timer is enabled, a halt also gives that timer a one-cycle restart pulse.

Top module: `insn_step_seq`

## Requirements
- R1: While reset is held and right after it, halted_o is 1, fetch_o, exec_o, done_o and timer_restart_o are 0, and pc_o is 0.
- R2: A start_i pulse while halted loads pc_o from entry_pc_i on the next edge and begins a fetch phase of 4 cycles.
- R3: A fetch phase lasts 2 cycles when the previously executed class was ALU (code 0) or BRANCH (code 1), and 4 cycles for every other previous class.
- R4: Class ALU (code 0, which also covers NOP) and class BRANCH (code 1) execute for 2 cycles each.
- R5: Class MEM (code 2, load or store) executes for 4 cycles, REG_RD (code 3) for 4 cycles and REG_WR (code 4) for 8 cycles.
- R6: Class WAIT (code 5) executes for 2 plus wait_cnt_i cycles, where wait_cnt_i is sampled in the last fetch cycle and may be 0 up to its maximum (255 at default width).
- R7: Class HALT (code 6) executes for 2 cycles, then halted_o rises, pc_o stays at the halt's address, and no fetch follows until a start pulse.
- R8: On entry to halted after a HALT, timer_restart_o is 1 for exactly one cycle if wake_en_i was 1 in the final HALT execute cycle, and stays 0 otherwise.
- R9: Class EXT (code 7) stays in execute until a cycle with ext_done_i high and stall_i low, which is the last execute cycle.
- R10: Each cycle with stall_i high during fetch or execute freezes that phase and adds one cycle to it, including a stall in what would have been the last cycle; done_o is never high while stalled.
- R11: pc_o holds through both phases of an instruction and rises by one when execute of any class other than HALT ends.
- R12: start_i has no effect while the sequencer is fetching or executing.
- R13: done_o is high for exactly one cycle per instruction, in its final execute cycle, and class_o shows the latched class for the whole execute phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Resume pulse, honoured only while halted |
| entry_pc_i | input | PC_W | Address loaded on resume |
| class_i | input | 3 | Decoded class of the instruction being fetched |
| wait_cnt_i | input | WAIT_W | Wait-cycle operand of a WAIT instruction |
| stall_i | input | 1 | Memory-arbiter stall; freezes the current phase |
| ext_done_i | input | 1 | Completion of an externally timed execute |
| wake_en_i | input | 1 | Wakeup timer enabled |
| pc_o | output | PC_W | Program counter (word address) |
| fetch_o | output | 1 | Fetch strobe, high during the fetch phase |
| exec_o | output | 1 | High during the execute phase |
| halted_o | output | 1 | High while halted |
| done_o | output | 1 | One-cycle completion pulse in the final execute cycle |
| class_o | output | 3 | Latched class of the executing instruction |
| timer_restart_o | output | 1 | One-cycle wakeup-timer restart pulse on halt entry |

## Verification
A stall can arrive in the very cycle in which a phase would otherwise end, and the external completion input can likewise coincide with a stall. The bench raises stall_i on the last nominal cycle of a short fetch, and holds ext_done_i high through a stalled cycle of an EXT execute. It then judges the phase lengths seen at the ports: the stall must add exactly its own cycles, and the completion must land on the first unstalled cycle with done_o high just once. A start pulse that arrives mid-instruction is also checked, and must leave the running instruction and its address sequence unchanged.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        CLS_ALU    = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_MEM    = 3'd2,
        CLS_REG_RD = 3'd3,
        CLS_REG_WR = 3'd4,
        CLS_WAIT   = 3'd5,
        CLS_HALT   = 3'd6,
        CLS_EXT    = 3'd7
    } insn_class_e;

    typedef enum logic [1:0] {
        PH_HALTED = 2'd0,
        PH_FETCH  = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

endpackage

// File: rtl/seq_fetch_len.sv
module seq_fetch_len
    import seq_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int FETCH_SHORT = 2,
    parameter int FETCH_LONG  = 4
) (
    input  insn_class_e      prev_cls_i,
    output logic [CNT_W-1:0] len_o
);

    // Straight-line predecessors let the next word be read early.
    always_comb begin
        case (prev_cls_i)
            CLS_ALU, CLS_BRANCH: len_o = CNT_W'(FETCH_SHORT);
            default:             len_o = CNT_W'(FETCH_LONG);
        endcase
    end

endmodule

// File: rtl/seq_exec_len.sv
module seq_exec_len
    import seq_pkg::*;
#(
    parameter int CNT_W          = 10,
    parameter int WAIT_W         = 8,
    parameter int EXEC_ALU       = 2,
    parameter int EXEC_BRANCH    = 2,
    parameter int EXEC_MEM       = 4,
    parameter int EXEC_REG_RD    = 4,
    parameter int EXEC_REG_WR    = 8,
    parameter int EXEC_WAIT_BASE = 2,
    parameter int EXEC_HALT      = 2
) (
    input  insn_class_e       cls_i,
    input  logic [WAIT_W-1:0] wait_i,
    output logic [CNT_W-1:0]  len_o,
    output logic              ext_o
);

    always_comb begin
        ext_o = 1'b0;
        case (cls_i)
            CLS_ALU:    len_o = CNT_W'(EXEC_ALU);
            CLS_BRANCH: len_o = CNT_W'(EXEC_BRANCH);
            CLS_MEM:    len_o = CNT_W'(EXEC_MEM);
            CLS_REG_RD: len_o = CNT_W'(EXEC_REG_RD);
            CLS_REG_WR: len_o = CNT_W'(EXEC_REG_WR);
            CLS_WAIT:   len_o = CNT_W'(EXEC_WAIT_BASE) + CNT_W'(wait_i);
            CLS_HALT:   len_o = CNT_W'(EXEC_HALT);
            default: begin
                // Externally timed: length is set by the completion input.
                len_o = CNT_W'(1);
                ext_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/insn_step_seq.sv
module insn_step_seq
    import seq_pkg::*;
#(
    parameter int PC_W           = 11,
    parameter int WAIT_W         = 8,
    parameter int FETCH_SHORT    = 2,
    parameter int FETCH_LONG     = 4,
    parameter int EXEC_ALU       = 2,
    parameter int EXEC_BRANCH    = 2,
    parameter int EXEC_MEM       = 4,
    parameter int EXEC_REG_RD    = 4,
    parameter int EXEC_REG_WR    = 8,
    parameter int EXEC_WAIT_BASE = 2,
    parameter int EXEC_HALT      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PC_W-1:0]   entry_pc_i,
    input  logic [2:0]        class_i,
    input  logic [WAIT_W-1:0] wait_cnt_i,
    input  logic              stall_i,
    input  logic              ext_done_i,
    input  logic              wake_en_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              fetch_o,
    output logic              exec_o,
    output logic              halted_o,
    output logic              done_o,
    output logic [2:0]        class_o,
    output logic              timer_restart_o
);

    // Counter must hold the longest wait execute: base + 2^WAIT_W - 1.
    localparam int CNT_W = WAIT_W + 2;

    typedef struct packed {
        phase_e          phase;
        logic [PC_W-1:0] pc;
        insn_class_e     cls;
        logic            ext;
        logic [CNT_W-1:0] cnt;
        logic            restart;
    } seq_state_t;

    localparam seq_state_t RESET_ST = '{
        phase:   PH_HALTED,
        pc:      '0,
        cls:     CLS_ALU,
        ext:     1'b0,
        cnt:     '0,
        restart: 1'b0
    };

    seq_state_t st_d, st_q;

    insn_class_e      new_cls;
    logic [CNT_W-1:0] exec_len;
    logic             exec_ext;
    logic [CNT_W-1:0] fetch_len;
    logic             phase_end;

    assign new_cls = insn_class_e'(class_i);

    seq_exec_len #(
        .CNT_W          (CNT_W),
        .WAIT_W         (WAIT_W),
        .EXEC_ALU       (EXEC_ALU),
        .EXEC_BRANCH    (EXEC_BRANCH),
        .EXEC_MEM       (EXEC_MEM),
        .EXEC_REG_RD    (EXEC_REG_RD),
        .EXEC_REG_WR    (EXEC_REG_WR),
        .EXEC_WAIT_BASE (EXEC_WAIT_BASE),
        .EXEC_HALT      (EXEC_HALT)
    ) u_exec_len (
        .cls_i  (new_cls),
        .wait_i (wait_cnt_i),
        .len_o  (exec_len),
        .ext_o  (exec_ext)
    );

    // The fetch that follows an execute depends on the class just retired.
    seq_fetch_len #(
        .CNT_W       (CNT_W),
        .FETCH_SHORT (FETCH_SHORT),
        .FETCH_LONG  (FETCH_LONG)
    ) u_fetch_len (
        .prev_cls_i (st_q.cls),
        .len_o      (fetch_len)
    );

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        phase_end    = 1'b0;
        done_o       = 1'b0;

        case (st_q.phase)
            PH_HALTED: begin
                if (start_i) begin
                    st_d.phase = PH_FETCH;
                    st_d.pc    = entry_pc_i;
                    st_d.cnt   = CNT_W'(FETCH_LONG - 1);
                end
            end

            PH_FETCH: begin
                if (!stall_i) begin
                    if (st_q.cnt == '0) begin
                        // Class and operand are captured in the last fetch cycle.
                        st_d.phase = PH_EXEC;
                        st_d.cls   = new_cls;
                        st_d.ext   = exec_ext;
                        st_d.cnt   = exec_len - CNT_W'(1);
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                    end
                end
            end

            PH_EXEC: begin
                if (!stall_i) begin
                    phase_end = st_q.ext ? ext_done_i : (st_q.cnt == '0);
                    if (phase_end) begin
                        done_o = 1'b1;
                        if (st_q.cls == CLS_HALT) begin
                            st_d.phase   = PH_HALTED;
                            st_d.restart = wake_en_i;
                        end else begin
                            st_d.phase = PH_FETCH;
                            st_d.pc    = st_q.pc + PC_W'(1);
                            st_d.cnt   = fetch_len - CNT_W'(1);
                        end
                    end else if (!st_q.ext) begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                    end
                end
            end

            default: st_d = RESET_ST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o            = st_q.pc;
    assign fetch_o         = (st_q.phase == PH_FETCH);
    assign exec_o          = (st_q.phase == PH_EXEC);
    assign halted_o        = (st_q.phase == PH_HALTED);
    assign class_o         = st_q.cls;
    assign timer_restart_o = st_q.restart;

    // Resume loads the entry address and starts a fetch.
    AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && start_i) |=> (fetch_o && pc_o == $past(entry_pc_i))); // R2

    // The address never moves except at the end of an execute or on resume.
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && !done_o) |=> $stable(pc_o)); // R11

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && class_o != 3'd6) |=> (fetch_o && pc_o == $past(pc_o) + PC_W'(1))); // R11

    AST_HALT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && class_o == 3'd6) |=> (halted_o && !fetch_o && $stable(pc_o))); // R7

    AST_RESTART_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        timer_restart_o |-> (halted_o && $past(wake_en_i) && $past(done_o))); // R8

    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        timer_restart_o |=> !timer_restart_o); // R8

    AST_DONE_UNSTALLED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (exec_o && !stall_i)); // R10

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !halted_o) |=> ($stable(fetch_o) && $stable(exec_o) && $stable(class_o))); // R10

    AST_EXT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && class_o == 3'd7 && !ext_done_i) |=> exec_o); // R9

    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R13

endmodule

// File: tb/insn_step_seq_bench.sv
`timescale 1ns/1ps
module insn_step_seq_bench;

    localparam int  PC_W   = 11;
    localparam int  WAIT_W = 8;
    localparam real HALF   = 2.5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [PC_W-1:0]   entry_pc_i = '0;
    logic [2:0]        class_i = '0;
    logic [WAIT_W-1:0] wait_cnt_i = '0;
    logic              stall_i = 1'b0;
    logic              ext_done_i = 1'b0;
    logic              wake_en_i = 1'b0;
    logic [PC_W-1:0]   pc_o;
    logic              fetch_o, exec_o, halted_o, done_o, timer_restart_o;
    logic [2:0]        class_o;

    int checks = 0;
    int fails  = 0;
    bit over   = 1'b0;

    always #(HALF) clk = ~clk;

    insn_step_seq u_insn_step_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .entry_pc_i      (entry_pc_i),
        .class_i         (class_i),
        .wait_cnt_i      (wait_cnt_i),
        .stall_i         (stall_i),
        .ext_done_i      (ext_done_i),
        .wake_en_i       (wake_en_i),
        .pc_o            (pc_o),
        .fetch_o         (fetch_o),
        .exec_o          (exec_o),
        .halted_o        (halted_o),
        .done_o          (done_o),
        .class_o         (class_o),
        .timer_restart_o (timer_restart_o)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Scenario: reset values (R1).
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(halted_o == 1'b1, "R1 halted in reset", halted_o, 1);
        chk(fetch_o == 1'b0 && exec_o == 1'b0, "R1 no phase in reset", {fetch_o, exec_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_o == '0, "R1 pc after reset", pc_o, 0);
        chk(done_o == 1'b0 && timer_restart_o == 1'b0, "R1 pulses idle", {done_o, timer_restart_o}, 0);
        chk(halted_o == 1'b1, "R1 halted after reset", halted_o, 1);
    endtask

    // Scenario: resume from halt (R2); ends on the first fetch cycle.
    task automatic t_start(input logic [PC_W-1:0] entry);
        entry_pc_i = entry;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        entry_pc_i = '0;
        chk(fetch_o == 1'b1, "R2 fetch after start", fetch_o, 1);
        chk(pc_o == entry, "R2 pc loaded from entry", pc_o, int'(entry));
    endtask

    // Scenario: one instruction, entered on its first fetch cycle.
    // sph selects the stalled phase (0 fetch, 1 execute); stalls fall on
    // phase cycles sat+1 .. sat+sn. ext_at > 0 raises ext_done_i from that
    // execute cycle on.
    task automatic run_insn(input logic [2:0] cls, input int wt, input int sph,
                            input int sat, input int sn, input int ext_at,
                            input int ef, input int ee, input string tag);
        int nf = 0;
        int ne = 0;
        int nd = 0;
        int done_at = 0;
        logic [PC_W-1:0] pc0;
        logic [2:0] seen_cls;
        bit cls_ok = 1'b1;
        pc0        = pc_o;
        class_i    = cls;
        wait_cnt_i = WAIT_W'(wt);
        while (fetch_o && nf < 2000) begin
            nf++;
            stall_i = (sph == 0 && sn > 0 && nf > sat && nf <= sat + sn);
            @(negedge clk);
            start_i = 1'b0;
            entry_pc_i = '0;
        end
        seen_cls = class_o;
        while (exec_o && ne < 2000) begin
            ne++;
            stall_i    = (sph == 1 && sn > 0 && ne > sat && ne <= sat + sn);
            ext_done_i = (ext_at > 0 && ne >= ext_at);
            if (class_o != cls) cls_ok = 1'b0;
            #1;
            if (done_o) begin
                nd++;
                done_at = ne;
            end
            @(negedge clk);
        end
        stall_i    = 1'b0;
        ext_done_i = 1'b0;
        chk(nf == ef, {tag, " fetch length"}, nf, ef);
        chk(ne == ee, {tag, " execute length"}, ne, ee);
        chk(nd == 1 && done_at == ne, {tag, " R13 single done in last cycle"}, nd * 1000 + done_at, 1000 + ne);
        chk(cls_ok && seen_cls == cls, {tag, " R13 class held"}, int'(seen_cls), int'(cls));
        if (cls == 3'd6)
            chk(pc_o == pc0 && halted_o, {tag, " R7 halt keeps pc and parks"}, pc_o, int'(pc0));
        else
            chk(pc_o == pc0 + PC_W'(1) && fetch_o, {tag, " R11 pc advances"}, pc_o, int'(pc0 + PC_W'(1)));
    endtask

    // Scenario: after a halt, the restart pulse and idle state (R7, R8).
    task automatic t_parked(input bit exp_pulse);
        bit fetched = 1'b0;
        chk(timer_restart_o == exp_pulse, "R8 restart pulse on halt entry", timer_restart_o, exp_pulse);
        @(negedge clk);
        chk(timer_restart_o == 1'b0, "R8 restart pulse one cycle", timer_restart_o, 0);
        for (int i = 0; i < 6; i++) begin
            if (fetch_o || !halted_o) fetched = 1'b1;
            @(negedge clk);
        end
        chk(!fetched, "R7 no fetch while halted", fetched, 0);
    endtask

    initial begin
        t_reset();
        t_start(11'h010);
        // Class codes: 0 ALU, 1 BRANCH, 2 MEM, 3 REG_RD, 4 REG_WR, 5 WAIT, 6 HALT, 7 EXT.
        run_insn(3'd0, 0, 0, 0, 0, 0, 4, 2, "R2 R4 alu first");
        run_insn(3'd0, 0, 0, 0, 0, 0, 2, 2, "R3 R4 alu after alu");
        run_insn(3'd1, 0, 0, 0, 0, 0, 2, 2, "R3 R4 branch");
        run_insn(3'd2, 0, 0, 0, 0, 0, 2, 4, "R3 R5 mem after branch");
        run_insn(3'd3, 0, 0, 0, 0, 0, 4, 4, "R3 R5 reg read");
        run_insn(3'd4, 0, 0, 0, 0, 0, 4, 8, "R5 reg write");
        run_insn(3'd5, 5, 0, 0, 0, 0, 4, 7, "R6 wait 5");
        run_insn(3'd5, 0, 0, 0, 0, 0, 4, 2, "R6 wait 0");
        run_insn(3'd7, 0, 0, 0, 0, 5, 4, 5, "R9 ext done at 5");
        // Start pulse mid-instruction must be ignored (R12).
        entry_pc_i = 11'h7F0;
        start_i    = 1'b1;
        run_insn(3'd1, 0, 0, 0, 0, 0, 4, 2, "R12 start ignored");
        // Stall on the last nominal cycle of a short fetch (R10).
        run_insn(3'd2, 0, 0, 1, 2, 0, 4, 4, "R10 fetch stall at end");
        run_insn(3'd2, 0, 1, 1, 3, 0, 4, 7, "R10 execute stall");
        // Completion and stall in the same cycle (R9, R10).
        run_insn(3'd7, 0, 1, 2, 1, 3, 4, 4, "R9 R10 ext done under stall");
        run_insn(3'd0, 0, 0, 0, 0, 0, 4, 2, "R3 alu after ext");
        wake_en_i = 1'b1;
        run_insn(3'd6, 0, 0, 0, 0, 0, 2, 2, "R7 halt");
        t_parked(1'b1);
        wake_en_i = 1'b0;
        t_start(11'h020);
        run_insn(3'd6, 0, 0, 0, 0, 0, 4, 2, "R7 halt timer off");
        t_parked(1'b0);
        t_start(11'h7FF);
        run_insn(3'd5, 255, 0, 0, 0, 0, 4, 257, "R6 wait max");
        chk(pc_o == '0, "R11 pc wraps", pc_o, 0);
        if (!over) begin
            over = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(HALF * 2 * 100000);
        if (!over) begin
            over = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule